// File: doc/BRIEF.md
# Thread-Block Resource Admission Controller

This block decides whether a compute thread block may start on one processing cluster. The cluster has four shared pools: 32-bit registers, shared-memory bytes, warp slots and block slots. A requester presents a block shape (thread count, registers per thread, shared-memory bytes). The controller derives the block's demand on each pool. It admits the block only when every pool can cover that demand at once. On admission it deducts the demand and records it against a block slot number that it hands back.

When a block finishes, its slot number is presented on the release port. The recorded demand flows back into every pool. A release and an admission may share a cycle, and the pools then move by the difference. The controller also reports the active warp count, the active block count and the free register and shared-memory capacity. It reports a static fit count as well: how many copies of the presented shape would fit on an empty cluster.

Top module: `tblk_admit`

## Requirements
- R1: After reset, free_regs is 65536, free_shm is 262144, active_warps is 0 and active_blocks is 0.
- R2: The warp demand of a request is its thread count divided by 32, rounded up to whole warps (100 threads need 4 warps, 33 need 2).
- R3: The register demand of a request is thread count times registers per thread, and an admitted block lowers free_regs by exactly that amount.
- R4: A valid, error-free request is admitted (req_ready high) only when free registers, free shared memory and free warp slots each cover its demand and at least one of the 32 block slots is free. Otherwise req_ready is low and no pool changes.
- R5: An admission lowers free_shm by the shared-memory demand, raises active_warps by the warp demand and active_blocks by one. grant_slot names the lowest-numbered free block slot.
- R6: A release of an occupied slot returns that slot's recorded register, shared-memory and warp demand and frees the slot. A release naming an unoccupied slot changes nothing.
- R7: When an admission and a release fall in the same cycle, every pool ends at its old value minus the new demand plus the returned demand. The admission decision uses the pool state from before that cycle's release.
- R8: A request with zero threads, more than 64 warps, more than 65536 registers or more than 262144 shared bytes raises req_err. It is consumed with req_ready high, and nothing is deducted.
- R9: fit_count equals the minimum of 65536 / register demand, 262144 / shared demand, 64 / warp demand and 32, in integer division. A zero register or shared demand leaves its term unlimited. fit_count is 0 for a request that R8 flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A block shape is presented |
| req_threads | input | 12 | Threads in the block |
| req_regs_per_thr | input | 8 | Registers needed per thread |
| req_shm_bytes | input | 19 | Shared-memory bytes needed |
| req_ready | output | 1 | The request is consumed this cycle (admitted, or rejected by error) |
| req_err | output | 1 | The presented request can never be admitted |
| grant_slot | output | 5 | Block slot assigned when admitted |
| rel_valid | input | 1 | A finished block is returned |
| rel_slot | input | 5 | Slot of the returned block |
| free_regs | output | 17 | Registers not held by any block |
| free_shm | output | 19 | Shared-memory bytes not held by any block |
| active_warps | output | 7 | Warp slots held by resident blocks |
| active_blocks | output | 6 | Block slots in use |
| fit_count | output | 6 | Copies of the presented shape that fit an empty cluster |

## Verification
A pool counter that drifts from the slot records shows at once on free_regs, free_shm or active_warps, one cycle after the admission or release that caused it. It shows again when the slot is later freed, because the returned amount then fails to restore full capacity. A wrong slot choice or occupancy mask shows on grant_slot at the next request, and as a wrong return amount on a later release. A demand or fit-count error is combinational, so it appears on fit_count, req_err and req_ready in the same cycle the shape is presented.

// File: rtl/tblk_admit_pkg.sv
package tblk_admit_pkg;
  localparam int unsigned REG_POOL  = 65536;
  localparam int unsigned SHM_POOL  = 262144;
  localparam int unsigned WARP_POOL = 64;
  localparam int unsigned BLK_POOL  = 32;
  localparam int unsigned WARP_SIZE = 32;

  localparam int unsigned THR_W  = 12;
  localparam int unsigned RPT_W  = 8;
  localparam int unsigned SHM_W  = $clog2(SHM_POOL + 1);
  localparam int unsigned REG_W  = $clog2(REG_POOL + 1);
  localparam int unsigned WRP_W  = $clog2(WARP_POOL + 1);
  localparam int unsigned BLK_W  = $clog2(BLK_POOL + 1);
  localparam int unsigned SLOT_W = $clog2(BLK_POOL);
  localparam int unsigned RDEM_W = THR_W + RPT_W;
  localparam int unsigned WDEM_W = THR_W - $clog2(WARP_SIZE) + 1;

  // Whole warps needed for a thread count (rounded up).
  function automatic logic [WDEM_W-1:0] warps_of(input logic [THR_W-1:0] thr);
    logic [THR_W:0] t;
    t = {1'b0, thr} + (THR_W+1)'(WARP_SIZE - 1);
    return WDEM_W'(t / (THR_W+1)'(WARP_SIZE));
  endfunction

  function automatic logic [RDEM_W-1:0] regs_of(input logic [THR_W-1:0] thr,
                                                input logic [RPT_W-1:0] rpt);
    return RDEM_W'(thr) * RDEM_W'(rpt);
  endfunction

  function automatic int unsigned min2(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  // Copies of one shape that fit an empty cluster.
  function automatic int unsigned fit_of(input int unsigned rdem,
                                         input int unsigned sdem,
                                         input int unsigned wdem);
    int unsigned f;
    f = BLK_POOL;
    if (rdem != 0) f = min2(f, REG_POOL / rdem);
    if (sdem != 0) f = min2(f, SHM_POOL / sdem);
    if (wdem != 0) f = min2(f, WARP_POOL / wdem);
    return f;
  endfunction
endpackage

// File: rtl/tblk_demand.sv
module tblk_demand
  import tblk_admit_pkg::*;
(
  input  logic [THR_W-1:0]  thr,
  input  logic [RPT_W-1:0]  rpt,
  input  logic [SHM_W-1:0]  shm,
  output logic [REG_W-1:0]  dem_regs,
  output logic [SHM_W-1:0]  dem_shm,
  output logic [WRP_W-1:0]  dem_warps,
  output logic              dem_err,
  output logic [BLK_W-1:0]  fit
);
  logic [RDEM_W-1:0] rd_full;
  logic [WDEM_W-1:0] wd_full;
  int unsigned       fit_raw;

  always_comb begin
    rd_full = regs_of(thr, rpt);
    wd_full = warps_of(thr);
    dem_err = (thr == '0)
           || (32'(wd_full) > WARP_POOL)
           || (32'(rd_full) > REG_POOL)
           || (32'(shm) > SHM_POOL);
    fit_raw   = fit_of(32'(rd_full), 32'(shm), 32'(wd_full));
    fit       = dem_err ? '0 : BLK_W'(fit_raw);
    dem_regs  = REG_W'(rd_full);
    dem_shm   = shm;
    dem_warps = WRP_W'(wd_full);
  end

  // R9: a shape flagged in error never reports a fit
  always_comb begin
    p_err_no_fit_r9: assert (!(dem_err && fit != '0));
  end
  // R2: a non-error shape needs between 1 and 64 warps
  always_comb begin
    p_warp_range_r2: assert (dem_err || (dem_warps != '0 && 32'(dem_warps) <= WARP_POOL));
  end
endmodule

// File: rtl/tblk_pool.sv
module tblk_pool #(
  parameter int unsigned W   = 8,
  parameter int unsigned CAP = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] take_amt,
  input  logic         give,
  input  logic [W-1:0] give_amt,
  output logic [W-1:0] free_q
);
  logic [W:0] nxt;

  always_comb begin
    nxt = {1'b0, free_q};
    if (take) nxt = nxt - {1'b0, take_amt};
    if (give) nxt = nxt + {1'b0, give_amt};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= W'(CAP);
    else        free_q <= nxt[W-1:0];
  end

  // R4: never deduct more than is free
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (take_amt <= free_q));
  // R6: free capacity never exceeds the pool size
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_q) <= CAP);
  // R7: the pool moves by exactly the net of take and give
  p_net_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (W+1)'(free_q) == (W+1)'($past(free_q))
               - ($past(take) ? (W+1)'($past(take_amt)) : '0)
               + ($past(give) ? (W+1)'($past(give_amt)) : '0));
endmodule

// File: rtl/tblk_slot_table.sv
module tblk_slot_table
  import tblk_admit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [REG_W-1:0]  alloc_regs,
  input  logic [SHM_W-1:0]  alloc_shm,
  input  logic [WRP_W-1:0]  alloc_warps,
  output logic [SLOT_W-1:0] alloc_slot,
  output logic              any_free,
  input  logic              rel_valid,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic              rel_hit,
  output logic [REG_W-1:0]  rel_regs,
  output logic [SHM_W-1:0]  rel_shm,
  output logic [WRP_W-1:0]  rel_warps,
  output logic [BLK_POOL-1:0] occ
);
  logic [REG_W-1:0] rec_regs  [BLK_POOL];
  logic [SHM_W-1:0] rec_shm   [BLK_POOL];
  logic [WRP_W-1:0] rec_warps [BLK_POOL];

  always_comb begin
    alloc_slot = '0;
    any_free   = 1'b0;
    for (int i = BLK_POOL - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        alloc_slot = SLOT_W'(i);
        any_free   = 1'b1;
      end
    end
  end

  assign rel_hit   = rel_valid && occ[rel_slot];
  assign rel_regs  = rec_regs[rel_slot];
  assign rel_shm   = rec_shm[rel_slot];
  assign rel_warps = rec_warps[rel_slot];

  for (genvar g = 0; g < BLK_POOL; g++) begin : g_slot
    logic set_g, clr_g;
    assign set_g = alloc && (alloc_slot == SLOT_W'(g));
    assign clr_g = rel_hit && (rel_slot == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ[g]          <= 1'b0;
        rec_regs[g]     <= '0;
        rec_shm[g]      <= '0;
        rec_warps[g]    <= '0;
      end else if (set_g) begin
        occ[g]          <= 1'b1;
        rec_regs[g]     <= alloc_regs;
        rec_shm[g]      <= alloc_shm;
        rec_warps[g]    <= alloc_warps;
      end else if (clr_g) begin
        occ[g]          <= 1'b0;
      end
    end
  end

  // R5: allocation only from a free slot
  p_alloc_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> any_free);
  // R5: the allocated slot is occupied afterwards
  p_alloc_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> occ[$past(alloc_slot)]);
  // R6: a miss release leaves occupancy unchanged unless an allocation happened
  p_miss_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rel_hit && !alloc) |=> $stable(occ));
endmodule

// File: rtl/tblk_admit.sv
module tblk_admit
  import tblk_admit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [THR_W-1:0]  req_threads,
  input  logic [RPT_W-1:0]  req_regs_per_thr,
  input  logic [SHM_W-1:0]  req_shm_bytes,
  output logic              req_ready,
  output logic              req_err,
  output logic [SLOT_W-1:0] grant_slot,
  input  logic              rel_valid,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic [REG_W-1:0]  free_regs,
  output logic [SHM_W-1:0]  free_shm,
  output logic [WRP_W-1:0]  active_warps,
  output logic [BLK_W-1:0]  active_blocks,
  output logic [BLK_W-1:0]  fit_count
);
  logic [REG_W-1:0] dem_regs;
  logic [SHM_W-1:0] dem_shm;
  logic [WRP_W-1:0] dem_warps;
  logic             dem_err;
  logic [WRP_W-1:0] free_warps;
  logic [BLK_W-1:0] free_blks;
  logic             fits_all;
  logic             grant_ev;
  logic             any_free;
  logic             rel_hit;
  logic [REG_W-1:0] rel_regs;
  logic [SHM_W-1:0] rel_shm;
  logic [WRP_W-1:0] rel_warps;
  logic [BLK_POOL-1:0] occ;

  tblk_demand u_demand (
    .thr(req_threads), .rpt(req_regs_per_thr), .shm(req_shm_bytes),
    .dem_regs(dem_regs), .dem_shm(dem_shm), .dem_warps(dem_warps),
    .dem_err(dem_err), .fit(fit_count)
  );

  assign fits_all = (dem_regs <= free_regs) && (dem_shm <= free_shm)
                 && (dem_warps <= free_warps) && (free_blks != '0);
  assign grant_ev  = req_valid && !dem_err && fits_all;
  assign req_ready = dem_err || fits_all;
  assign req_err   = req_valid && dem_err;

  tblk_pool #(.W(REG_W), .CAP(REG_POOL)) u_pool_regs (
    .clk(clk), .rst_n(rst_n), .take(grant_ev), .take_amt(dem_regs),
    .give(rel_hit), .give_amt(rel_regs), .free_q(free_regs));
  tblk_pool #(.W(SHM_W), .CAP(SHM_POOL)) u_pool_shm (
    .clk(clk), .rst_n(rst_n), .take(grant_ev), .take_amt(dem_shm),
    .give(rel_hit), .give_amt(rel_shm), .free_q(free_shm));
  tblk_pool #(.W(WRP_W), .CAP(WARP_POOL)) u_pool_warps (
    .clk(clk), .rst_n(rst_n), .take(grant_ev), .take_amt(dem_warps),
    .give(rel_hit), .give_amt(rel_warps), .free_q(free_warps));
  tblk_pool #(.W(BLK_W), .CAP(BLK_POOL)) u_pool_blks (
    .clk(clk), .rst_n(rst_n), .take(grant_ev), .take_amt(BLK_W'(1)),
    .give(rel_hit), .give_amt(BLK_W'(1)), .free_q(free_blks));

  tblk_slot_table u_slots (
    .clk(clk), .rst_n(rst_n),
    .alloc(grant_ev), .alloc_regs(dem_regs), .alloc_shm(dem_shm),
    .alloc_warps(dem_warps), .alloc_slot(grant_slot), .any_free(any_free),
    .rel_valid(rel_valid), .rel_slot(rel_slot), .rel_hit(rel_hit),
    .rel_regs(rel_regs), .rel_shm(rel_shm), .rel_warps(rel_warps), .occ(occ));

  assign active_warps  = WRP_W'(WARP_POOL) - free_warps;
  assign active_blocks = BLK_W'(BLK_POOL) - free_blks;

  // R5: the block-slot pool agrees with the occupancy mask
  p_blk_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(active_blocks) == 32'($countones(occ)));
  // R5: free-slot search agrees with the block counter
  p_any_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_free == (free_blks != '0));
  // R8: an error request is never admitted
  p_err_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> (free_regs == $past(free_regs) + ($past(rel_hit) ? $past(rel_regs) : '0)));
  // R4: a stalled request leaves the warp pool alone unless a release happens
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !rel_hit) |=> $stable(active_warps));
  // R1: nothing is resident right after reset
  p_reset_empty_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (active_blocks == '0 && free_regs == REG_W'(REG_POOL)));
endmodule

// File: tb/test_tblk_admit.sv
module test_tblk_admit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_threads = '0;
  logic [7:0]  req_regs_per_thr = '0;
  logic [18:0] req_shm_bytes = '0;
  logic        req_ready, req_err;
  logic [4:0]  grant_slot;
  logic        rel_valid = 1'b0;
  logic [4:0]  rel_slot = '0;
  logic [16:0] free_regs;
  logic [18:0] free_shm;
  logic [6:0]  active_warps;
  logic [5:0]  active_blocks, fit_count;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tblk_admit i_tblk_admit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
    .req_regs_per_thr(req_regs_per_thr), .req_shm_bytes(req_shm_bytes),
    .req_ready(req_ready), .req_err(req_err), .grant_slot(grant_slot),
    .rel_valid(rel_valid), .rel_slot(rel_slot), .free_regs(free_regs),
    .free_shm(free_shm), .active_warps(active_warps),
    .active_blocks(active_blocks), .fit_count(fit_count));

  typedef struct packed {
    logic [11:0] thr;
    logic [7:0]  rpt;
    logic [18:0] shm;
    logic [5:0]  fit;
    logic        err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{12'd256,  8'd32,  19'd4096,   6'd8,  1'b0},
    '{12'd100,  8'd10,  19'd0,      6'd16, 1'b0},
    '{12'd32,   8'd0,   19'd0,      6'd32, 1'b0},
    '{12'd0,    8'd10,  19'd10,     6'd0,  1'b1},
    '{12'd2048, 8'd32,  19'd0,      6'd1,  1'b0},
    '{12'd2049, 8'd1,   19'd0,      6'd0,  1'b1},
    '{12'd1024, 8'd65,  19'd0,      6'd0,  1'b1},
    '{12'd64,   8'd16,  19'd262145, 6'd0,  1'b1},
    '{12'd64,   8'd16,  19'd262144, 6'd1,  1'b0},
    '{12'd33,   8'd8,   19'd1000,   6'd32, 1'b0},
    '{12'd512,  8'd128, 19'd65536,  6'd1,  1'b0},
    '{12'd96,   8'd100, 19'd20000,  6'd6,  1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic state_chk(input string req, input int regs, input int shm,
                           input int warps, input int blks);
    chk(free_regs == 17'(regs), req, "free_regs", free_regs, regs);
    chk(free_shm == 19'(shm), req, "free_shm", free_shm, shm);
    chk(active_warps == 7'(warps), req, "active_warps", active_warps, warps);
    chk(active_blocks == 6'(blks), req, "active_blocks", active_blocks, blks);
  endtask

  // Present one request for one cycle, check the combinational answer,
  // release an optional slot in the same cycle.
  task automatic present(input int thr, input int rpt, input int shm,
                         input bit exp_ready, input int exp_slot,
                         input bit do_rel, input int rslot, input string req);
    @(negedge clk);
    req_valid = 1'b1;
    req_threads = 12'(thr);
    req_regs_per_thr = 8'(rpt);
    req_shm_bytes = 19'(shm);
    rel_valid = do_rel;
    rel_slot = 5'(rslot);
    #1;
    chk(req_ready == exp_ready, req, "req_ready", req_ready, exp_ready);
    if (exp_ready && !req_err)
      chk(grant_slot == 5'(exp_slot), req, "grant_slot", grant_slot, exp_slot);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    rel_valid = 1'b0;
  endtask

  task automatic release_slot(input int s);
    @(negedge clk);
    rel_valid = 1'b1;
    rel_slot = 5'(s);
    @(posedge clk);
    #1;
    rel_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    do_reset();
    @(negedge clk);
    // R1: reset state
    state_chk("R1", 65536, 262144, 0, 0);

    // R9 / R8: fit and error table, request not valid so nothing changes
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_threads = VECS[i].thr;
      req_regs_per_thr = VECS[i].rpt;
      req_shm_bytes = VECS[i].shm;
      req_valid = 1'b1;
      #1;
      chk(fit_count == VECS[i].fit, "R9", "fit_count", fit_count, VECS[i].fit);
      chk(req_err == VECS[i].err, "R8", "req_err", req_err, VECS[i].err);
      req_valid = 1'b0;
    end
    // table walk never held req_valid across a clock edge
    @(negedge clk);
    state_chk("R8", 65536, 262144, 0, 0);

    // R2 / R3: 100 threads x 10 regs -> 4 warps, 1000 regs
    present(100, 10, 0, 1'b1, 0, 1'b0, 0, "R2");
    state_chk("R3", 64536, 262144, 4, 1);
    release_slot(0);
    state_chk("R6", 65536, 262144, 0, 0);

    // R2: 33 threads round up to 2 warps
    present(33, 8, 1000, 1'b1, 0, 1'b0, 0, "R2");
    state_chk("R2", 65536 - 264, 262144 - 1000, 2, 1);
    release_slot(0);

    // R5: eight blocks of 256 x 32 regs + 4 KB fill the warps
    for (int k = 0; k < 8; k++) begin
      present(256, 32, 4096, 1'b1, k, 1'b0, 0, "R5");
      state_chk("R5", 65536 - (k + 1) * 8192, 262144 - (k + 1) * 4096,
                (k + 1) * 8, k + 1);
    end
    // R4: one more warp does not fit
    present(32, 0, 0, 1'b0, 0, 1'b0, 0, "R4");
    state_chk("R4", 0, 262144 - 8 * 4096, 64, 8);

    // R8: error request consumed, nothing deducted
    present(0, 1, 1, 1'b1, 0, 1'b0, 0, "R8");
    state_chk("R8", 0, 262144 - 8 * 4096, 64, 8);

    // R6: release slot 3, then release it again (ignored)
    release_slot(3);
    state_chk("R6", 8192, 262144 - 7 * 4096, 56, 7);
    release_slot(3);
    state_chk("R6", 8192, 262144 - 7 * 4096, 56, 7);

    // R7: admission into slot 3 with a release of slot 5 in the same cycle
    present(256, 32, 4096, 1'b1, 3, 1'b1, 5, "R7");
    state_chk("R7", 8192, 262144 - 7 * 4096, 56, 7);
    // R7: decision uses pre-release state: warps full, release of 1 in same cycle
    present(256, 32, 4096, 1'b1, 5, 1'b0, 0, "R7");
    present(32, 0, 0, 1'b0, 0, 1'b1, 0, "R7");
    state_chk("R7", 8192, 262144 - 7 * 4096, 56, 7);

    // R4: block-slot limit with tiny blocks
    do_reset();
    @(negedge clk);
    state_chk("R1", 65536, 262144, 0, 0);
    for (int k = 0; k < 32; k++)
      present(32, 0, 0, 1'b1, k, 1'b0, 0, "R4");
    state_chk("R4", 65536, 262144, 32, 32);
    present(32, 0, 0, 1'b0, 0, 1'b0, 0, "R4");
    state_chk("R4", 65536, 262144, 32, 32);
    release_slot(17);
    present(32, 0, 0, 1'b1, 17, 1'b0, 0, "R5");
    state_chk("R5", 65536, 262144, 32, 32);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule